// File: doc/BRIEF.md
# Flash Program/Erase Host Sequencer

This block sits on the host side of a byte-wide parallel flash device. A requester hands it one operation at a time over a valid/ready handshake: program one byte, erase one sector, or erase the whole chip. The sequencer then drives the write train that the flash expects. Each train opens with unlock writes, and each write is a timed pulse of chip enable and write enable, with address and data held steady. Consecutive writes are separated by a recovery gap.

Once the train has gone out, the block reads the target location again and again until the status bits show that the internal operation has finished. It can use one of two checks. In data polling, bit 7 reads inverted while the flash is busy. In toggle mode, bit 6 flips on every read while the flash is busy. If the poll count runs out, the block writes the return-to-read command and reports an error. Otherwise it reports success. Either way the report is a one-cycle pulse.

Top module: `flash_prog_sequencer`

## Requirements
- R1: `reqReady` is high only when the block is idle. A request is taken on a clock edge where `reqValid` and `reqReady` are both high. `reqReady` then stays low until the cycle after the `doneOk` or `doneErr` pulse.
- R2: Op code 0 (program) emits four writes, as (address, data): (5555h, AAh), (2AAAh, 55h), (5555h, A0h), then (`reqAddr`, `reqData`).
- R3: Op code 1 (sector erase) emits six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), then (`reqAddr`, 30h).
- R4: Op code 2 (chip erase) emits six writes: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (5555h, 10h).
- R5: During every write, `flashCeN` and `flashWeN` are low together for exactly PULSE_CYC clocks. In that time `flashOeN` is high, `flashDoe` is high, and address and data do not change. Between two writes of one train, `flashWeN` is high for exactly GAP_CYC clocks.
- R6: With `reqToggleMode` at 0, the target address `reqAddr` is read until bit 7 of the read value equals the expected bit: bit 7 of `reqData` for a program, 1 for either erase. A run with B busy reads therefore takes B+1 reads and ends in `doneOk`.
- R7: With `reqToggleMode` at 1, polling ends with `doneOk` at the first read whose bit 6 equals bit 6 of the read just before it. At least two reads are always made.
- R8: If POLL_LIMIT reads pass without completion, the block makes one write of F0h to address 0 and then pulses `doneErr`.
- R9: `doneOk` and `doneErr` never go high together, and each stays high for a single cycle.
- R10: A request with op code 3 is accepted but answered with a `doneErr` pulse. No write and no read is made on the flash bus.
- R11: After reset, `flashCeN`, `flashWeN` and `flashOeN` are high, `flashDoe` is low, `reqReady` is high, and both done pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request can be accepted (idle) |
| reqOp | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 invalid |
| reqAddr | input | ADDR_W | Target byte or sector address |
| reqData | input | DATA_W | Byte to program |
| reqToggleMode | input | 1 | 0: data polling on bit 7, 1: toggle check on bit 6 |
| doneOk | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | One-cycle error pulse (timeout or invalid op) |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashWeN | output | 1 | Flash write enable, active low |
| flashOeN | output | 1 | Flash output enable, active low |
| flashAddr | output | ADDR_W | Flash address bus |
| flashDout | output | DATA_W | Data driven toward the flash |
| flashDoe | output | 1 | Drive enable for `flashDout` |
| flashDin | input | DATA_W | Data read from the flash |

## Verification
On every cycle, the embedded assertions check the bus-level rules. Write enable never appears without chip enable, and reads never overlap writes. The drive enable follows the cycle type, and address and data hold across a write pulse. The handshake rules are also checked every cycle: ready drops after acceptance, the done pulses last one cycle and exclude each other, and the poll counter stays in bounds.

Some behaviour can only be shown by the bench's scenarios, using a flash model that reports busy for a chosen number of reads. These are the exact content and order of each write train, the exact pulse and gap lengths, and the number of reads made under each completion rule. The same holds for the timeout path with its trailing F0h write, and for the rejection of the invalid op.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  typedef enum logic [1:0] {
    OP_PROGRAM = 2'd0,
    OP_SECTOR  = 2'd1,
    OP_CHIP    = 2'd2,
    OP_INVALID = 2'd3
  } fseqOp_e;

  // strobes from control to datapath, decoded from the control state
  typedef struct packed {
    logic       busCe;
    logic       busWe;
    logic       busOe;
    logic       busDrive;
    logic       loadReq;
    logic       sampleRd;
    logic       useReset;
    logic [2:0] wrIdx;
  } fseqStrobe_t;

  // status from datapath back to control
  typedef struct packed {
    logic lastWrite;
    logic pollHit;
  } fseqStatus_t;

  localparam logic [14:0] UNLOCK_HI = 15'h5555;
  localparam logic [14:0] UNLOCK_LO = 15'h2AAA;

endpackage

// File: rtl/fseq_datapath.sv
module fseq_datapath
  import fseq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fseqStrobe_t       strobe,
  output fseqStatus_t       status,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqToggleMode,
  output logic              flashCeN,
  output logic              flashWeN,
  output logic              flashOeN,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashDout,
  output logic              flashDoe,
  input  logic [DATA_W-1:0] flashDin
);

  localparam int BIT_POLL   = 7;
  localparam int BIT_TOGGLE = 6;

  fseqOp_e           opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic              toggleQ;

  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  logic              sampleQ;
  logic [DATA_W-1:0] curRd;
  logic              prevBit6;
  logic [1:0]        rdSeen;
  logic              expBit7;

  // request capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opQ     <= OP_PROGRAM;
      addrQ   <= '0;
      dataQ   <= '0;
      toggleQ <= 1'b0;
    end else if (strobe.loadReq) begin
      opQ     <= fseqOp_e'(reqOp);
      addrQ   <= reqAddr;
      dataQ   <= reqData;
      toggleQ <= reqToggleMode;
    end
  end

  // write content for each slot of a train
  always_comb begin
    wrAddr = ADDR_W'(UNLOCK_HI);
    wrData = DATA_W'(8'hAA);
    if (strobe.useReset) begin
      wrAddr = '0;
      wrData = DATA_W'(8'hF0);
    end else begin
      case (strobe.wrIdx)
        3'd0: begin
          wrAddr = ADDR_W'(UNLOCK_HI);
          wrData = DATA_W'(8'hAA);
        end
        3'd1: begin
          wrAddr = ADDR_W'(UNLOCK_LO);
          wrData = DATA_W'(8'h55);
        end
        3'd2: begin
          wrAddr = ADDR_W'(UNLOCK_HI);
          wrData = (opQ == OP_PROGRAM) ? DATA_W'(8'hA0) : DATA_W'(8'h80);
        end
        3'd3: begin
          if (opQ == OP_PROGRAM) begin
            wrAddr = addrQ;
            wrData = dataQ;
          end else begin
            wrAddr = ADDR_W'(UNLOCK_HI);
            wrData = DATA_W'(8'hAA);
          end
        end
        3'd4: begin
          wrAddr = ADDR_W'(UNLOCK_LO);
          wrData = DATA_W'(8'h55);
        end
        default: begin
          if (opQ == OP_SECTOR) begin
            wrAddr = addrQ;
            wrData = DATA_W'(8'h30);
          end else begin
            wrAddr = ADDR_W'(UNLOCK_HI);
            wrData = DATA_W'(8'h10);
          end
        end
      endcase
    end
  end

  // registered bus: every strobe lags the control state by one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flashCeN  <= 1'b1;
      flashWeN  <= 1'b1;
      flashOeN  <= 1'b1;
      flashDoe  <= 1'b0;
      flashAddr <= '0;
      flashDout <= '0;
      sampleQ   <= 1'b0;
    end else begin
      flashCeN <= ~strobe.busCe;
      flashWeN <= ~strobe.busWe;
      flashOeN <= ~strobe.busOe;
      flashDoe <= strobe.busDrive;
      sampleQ  <= strobe.sampleRd;
      if (strobe.busDrive) begin
        flashAddr <= wrAddr;
        flashDout <= wrData;
      end else if (strobe.busOe) begin
        flashAddr <= addrQ;
      end
    end
  end

  // read capture, keeps the previous toggle bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curRd    <= '0;
      prevBit6 <= 1'b0;
      rdSeen   <= '0;
    end else if (strobe.loadReq) begin
      rdSeen <= '0;
    end else if (sampleQ) begin
      curRd    <= flashDin;
      prevBit6 <= curRd[BIT_TOGGLE];
      if (rdSeen != 2'd2) rdSeen <= rdSeen + 2'd1;
    end
  end

  assign expBit7 = (opQ == OP_PROGRAM) ? dataQ[BIT_POLL] : 1'b1;

  always_comb begin
    status.lastWrite = (opQ == OP_PROGRAM) ? (strobe.wrIdx == 3'd3)
                                           : (strobe.wrIdx == 3'd5);
    if (toggleQ)
      status.pollHit = (rdSeen == 2'd2) && (curRd[BIT_TOGGLE] == prevBit6);
    else
      status.pollHit = (rdSeen != 2'd0) && (curRd[BIT_POLL] == expBit7);
  end

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !flashWeN |-> !flashCeN);  // R5
  AST_NO_READ_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !flashWeN |-> flashOeN);  // R5
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !flashWeN |-> flashDoe);  // R5
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !flashOeN |-> !flashDoe);  // R6
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!flashWeN && $past(!flashWeN)) |-> ($stable(flashAddr) && $stable(flashDout)));  // R5

endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int PULSE_CYC  = 3,
  parameter int GAP_CYC    = 2,
  parameter int POLL_LIMIT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  output logic        reqReady,
  output logic        doneOk,
  output logic        doneErr,
  output fseqStrobe_t strobe,
  input  fseqStatus_t status
);

  localparam int PULSE_EFF = (PULSE_CYC < 1) ? 1 : PULSE_CYC;
  localparam int GAP_EFF   = (GAP_CYC < 2) ? 2 : GAP_CYC;
  localparam int CNT_MAX   = (PULSE_EFF > GAP_EFF) ? PULSE_EFF : GAP_EFF;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int POLL_W    = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_WR_ACT, S_WR_GAP, S_RD_ACT, S_RD_GAP,
    S_RST_ACT, S_RST_GAP, S_FIN_OK, S_FIN_ERR
  } state_e;

  state_e            state;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        idx;
  logic [POLL_W-1:0] pollCnt;
  logic              pulseEnd;
  logic              gapEnd;
  logic              opBad;

  assign pulseEnd = (cnt == CNT_W'(PULSE_EFF - 1));
  assign gapEnd   = (cnt == CNT_W'(GAP_EFF - 1));
  assign opBad    = (fseqOp_e'(reqOp) == OP_INVALID);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      pollCnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt <= '0;
          idx <= '0;
          if (reqValid) state <= opBad ? S_FIN_ERR : S_WR_ACT;
        end
        S_WR_ACT: begin
          if (pulseEnd) begin
            cnt   <= '0;
            state <= S_WR_GAP;
          end else cnt <= cnt + 1'b1;
        end
        S_WR_GAP: begin
          if (gapEnd) begin
            cnt <= '0;
            if (status.lastWrite) begin
              pollCnt <= '0;
              state   <= S_RD_ACT;
            end else begin
              idx   <= idx + 3'd1;
              state <= S_WR_ACT;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_RD_ACT: begin
          if (pulseEnd) begin
            cnt   <= '0;
            state <= S_RD_GAP;
          end else cnt <= cnt + 1'b1;
        end
        S_RD_GAP: begin
          if (gapEnd) begin
            cnt     <= '0;
            pollCnt <= pollCnt + 1'b1;
            if (status.pollHit) state <= S_FIN_OK;
            else if (pollCnt == POLL_W'(POLL_LIMIT - 1)) state <= S_RST_ACT;
            else state <= S_RD_ACT;
          end else cnt <= cnt + 1'b1;
        end
        S_RST_ACT: begin
          if (pulseEnd) begin
            cnt   <= '0;
            state <= S_RST_GAP;
          end else cnt <= cnt + 1'b1;
        end
        S_RST_GAP: begin
          if (gapEnd) begin
            cnt   <= '0;
            state <= S_FIN_ERR;
          end else cnt <= cnt + 1'b1;
        end
        S_FIN_OK:  state <= S_IDLE;
        S_FIN_ERR: state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.wrIdx    = idx;
    strobe.loadReq  = (state == S_IDLE) && reqValid && !opBad;
    case (state)
      S_WR_ACT: begin
        strobe.busCe    = 1'b1;
        strobe.busWe    = 1'b1;
        strobe.busDrive = 1'b1;
      end
      S_WR_GAP: strobe.busDrive = 1'b1;
      S_RD_ACT: begin
        strobe.busCe    = 1'b1;
        strobe.busOe    = 1'b1;
        strobe.sampleRd = pulseEnd;
      end
      S_RST_ACT: begin
        strobe.busCe    = 1'b1;
        strobe.busWe    = 1'b1;
        strobe.busDrive = 1'b1;
        strobe.useReset = 1'b1;
      end
      S_RST_GAP: begin
        strobe.busDrive = 1'b1;
        strobe.useReset = 1'b1;
      end
      default: ;
    endcase
  end

  assign reqReady = (state == S_IDLE);
  assign doneOk   = (state == S_FIN_OK);
  assign doneErr  = (state == S_FIN_ERR);

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);  // R1
  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({doneOk, doneErr, reqReady}));  // R9
  AST_OK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    doneOk |=> !doneOk);  // R9
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    doneErr |=> !doneErr);  // R9
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pollCnt <= POLL_W'(POLL_LIMIT));  // R8
  AST_BAD_OP_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && opBad) |=> doneErr);  // R10

endmodule

// File: rtl/flash_prog_sequencer.sv
module flash_prog_sequencer
  import fseq_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int PULSE_CYC  = 3,
  parameter int GAP_CYC    = 2,
  parameter int POLL_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqToggleMode,
  output logic              doneOk,
  output logic              doneErr,
  output logic              flashCeN,
  output logic              flashWeN,
  output logic              flashOeN,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashDout,
  output logic              flashDoe,
  input  logic [DATA_W-1:0] flashDin
);

  fseqStrobe_t strobe;
  fseqStatus_t status;

  fseq_ctrl #(
    .PULSE_CYC (PULSE_CYC),
    .GAP_CYC   (GAP_CYC),
    .POLL_LIMIT(POLL_LIMIT)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .reqValid(reqValid),
    .reqOp   (reqOp),
    .reqReady(reqReady),
    .doneOk  (doneOk),
    .doneErr (doneErr),
    .strobe  (strobe),
    .status  (status)
  );

  fseq_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .status       (status),
    .reqOp        (reqOp),
    .reqAddr      (reqAddr),
    .reqData      (reqData),
    .reqToggleMode(reqToggleMode),
    .flashCeN     (flashCeN),
    .flashWeN     (flashWeN),
    .flashOeN     (flashOeN),
    .flashAddr    (flashAddr),
    .flashDout    (flashDout),
    .flashDoe     (flashDoe),
    .flashDin     (flashDin)
  );

endmodule

// File: tb/flash_prog_sequencer_test.sv
`timescale 1ns/1ps
module flash_prog_sequencer_test;

  localparam int ADDR_W = 19;
  localparam int DATA_W = 8;
  localparam int PULSE  = 3;
  localparam int GAP    = 2;
  localparam int LIMIT  = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [1:0]        reqOp = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic              reqToggleMode = 1'b0;
  logic              doneOk, doneErr;
  logic              flashCeN, flashWeN, flashOeN, flashDoe;
  logic [ADDR_W-1:0] flashAddr;
  logic [DATA_W-1:0] flashDout;
  logic [DATA_W-1:0] flashDin;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  flash_prog_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE),
    .GAP_CYC(GAP), .POLL_LIMIT(LIMIT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqData(reqData),
    .reqToggleMode(reqToggleMode), .doneOk(doneOk), .doneErr(doneErr),
    .flashCeN(flashCeN), .flashWeN(flashWeN), .flashOeN(flashOeN),
    .flashAddr(flashAddr), .flashDout(flashDout), .flashDoe(flashDoe),
    .flashDin(flashDin)
  );

  always #2 clk = ~clk;

  // ---------------- flash model ----------------
  int          mOp = 0;
  logic [7:0]  mData = '0;
  int          mBusy = 0;
  int          readCount = 0;
  int          readAddrBad = 0;
  logic [ADDR_W-1:0] mTarget = '0;
  int          wCount = 0;
  logic [ADDR_W-1:0] wAddr [16];
  logic [7:0]  wData [16];
  int          lowRun = 0, highRun = 0;
  int          widthBad = 0, gapBad = 0;

  function automatic logic [7:0] modelVal(input int i);
    logic [7:0] fin;
    logic       exp7;
    fin  = (mOp == 0) ? mData : 8'hFF;
    exp7 = fin[7];
    if (i < mBusy) return {~exp7, i[0], 6'b0};
    return fin;
  endfunction

  assign flashDin = modelVal(readCount);

  always @(posedge flashOeN) begin
    if (rst_n) begin
      if (flashAddr != mTarget) readAddrBad++;
      readCount++;
    end
  end

  always @(posedge flashWeN) begin
    if (rst_n) begin
      if (wCount < 16) begin
        wAddr[wCount] = flashAddr;
        wData[wCount] = flashDout;
      end
      wCount++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!flashWeN) begin
        if (highRun > 0 && wCount > 0 && readCount == 0 && highRun != GAP) gapBad++;
        highRun = 0;
        lowRun++;
      end else begin
        if (lowRun > 0 && lowRun != PULSE) widthBad++;
        lowRun = 0;
        highRun++;
      end
    end
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expAddr(input int op, input int k, input int tgt);
    case (k)
      0, 2: return 'h5555;
      1, 4: return 'h2AAA;
      3:    return (op == 0) ? tgt : 'h5555;
      default: return (op == 1) ? tgt : 'h5555;
    endcase
  endfunction

  function automatic int expData(input int op, input int k, input int d);
    case (k)
      0: return 'hAA;
      1, 4: return 'h55;
      2: return (op == 0) ? 'hA0 : 'h80;
      3: return (op == 0) ? d : 'hAA;
      default: return (op == 1) ? 'h30 : 'h10;
    endcase
  endfunction

  int gotOk, gotErr, pulseLen, readyAfter, readyLow;

  task automatic runOp(input int op, input int addr, input int data,
                       input bit tmode, input int busy);
    mOp = op; mData = data[7:0]; mBusy = busy;
    mTarget = addr[ADDR_W-1:0];
    readCount = 0; wCount = 0; readAddrBad = 0; widthBad = 0; gapBad = 0;
    gotOk = 0; gotErr = 0;
    @(negedge clk);
    reqOp = op[1:0]; reqAddr = addr[ADDR_W-1:0]; reqData = data[7:0];
    reqToggleMode = tmode; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    readyLow = !reqReady;
    for (int n = 0; n < 20000; n++) begin
      if (doneOk || doneErr) break;
      if (reqReady) readyLow = 0;
      @(negedge clk);
    end
    gotOk = doneOk; gotErr = doneErr;
    @(negedge clk);
    pulseLen = (doneOk || doneErr) ? 2 : 1;
    readyAfter = reqReady;
  endtask

  task automatic checkTrain(input int op, input int addr, input int data, input string tag);
    int n;
    n = (op == 0) ? 4 : 6;
    check(wCount == n, {tag, " write count"}, wCount, n);
    for (int k = 0; k < n; k++) begin
      check(int'(wAddr[k]) == expAddr(op, k, addr), {tag, " write address"},
            int'(wAddr[k]), expAddr(op, k, addr));
      check(int'(wData[k]) == expData(op, k, data), {tag, " write data"},
            int'(wData[k]), expData(op, k, data));
    end
    check(widthBad == 0, "R5 pulse width", widthBad, 0);
    check(gapBad == 0, "R5 recovery gap", gapBad, 0);
  endtask

  function automatic int toggleReads();
    for (int n = 2; n <= LIMIT; n++) begin
      logic [7:0] a, b;
      a = modelVal(n - 2);
      b = modelVal(n - 1);
      if (a[6] == b[6]) return n;
    end
    return LIMIT;
  endfunction

  // ---------------- scenarios ----------------
  task automatic testReset();
    check(flashCeN && flashWeN && flashOeN, "R11 strobes idle high", {flashCeN, flashWeN, flashOeN}, 7);
    check(!flashDoe, "R11 drive off", flashDoe, 0);
    check(reqReady, "R11 ready after reset", reqReady, 1);
    check(!doneOk && !doneErr, "R11 no done", {doneOk, doneErr}, 0);
  endtask

  task automatic testProgram(input int addr, input int data, input int busy);
    runOp(0, addr, data, 1'b0, busy);
    check(readyLow, "R1 ready low while busy", readyLow, 1);
    check(gotOk == 1 && gotErr == 0, "R6 program done ok", gotOk, 1);
    check(pulseLen == 1, "R9 done pulse one cycle", pulseLen, 1);
    check(readyAfter == 1, "R1 ready after done", readyAfter, 1);
    checkTrain(0, addr, data, "R2");
    check(readCount == busy + 1, "R6 data-poll read count", readCount, busy + 1);
    check(readAddrBad == 0, "R6 reads at target", readAddrBad, 0);
  endtask

  task automatic testSector();
    runOp(1, 'h6_0000, 0, 1'b0, 4);
    check(gotOk == 1, "R6 sector erase done ok", gotOk, 1);
    checkTrain(1, 'h6_0000, 0, "R3");
    check(readCount == 5, "R6 erase read count", readCount, 5);
  endtask

  task automatic testChipToggle(input int busy);
    int expN;
    runOp(2, 'h1_2345, 0, 1'b1, busy);
    expN = toggleReads();
    check(gotOk == 1, "R7 toggle done ok", gotOk, 1);
    checkTrain(2, 'h1_2345, 0, "R4");
    check(readCount == expN, "R7 toggle read count", readCount, expN);
  endtask

  task automatic testTimeout();
    runOp(0, 'h0_0777, 'h5A, 1'b0, 100000);
    check(gotErr == 1 && gotOk == 0, "R8 timeout error", gotErr, 1);
    check(pulseLen == 1, "R9 error pulse one cycle", pulseLen, 1);
    check(readCount == LIMIT, "R8 poll limit", readCount, LIMIT);
    check(wCount == 5, "R8 reset write issued", wCount, 5);
    check(wAddr[4] == '0 && wData[4] == 8'hF0, "R8 reset write content",
          int'(wData[4]), 'hF0);
  endtask

  task automatic testInvalid();
    runOp(3, 'h0_0100, 'h11, 1'b0, 0);
    check(gotErr == 1 && gotOk == 0, "R10 invalid op error", gotErr, 1);
    check(wCount == 0, "R10 no writes", wCount, 0);
    check(readCount == 0, "R10 no reads", readCount, 0);
    check(readyAfter == 1, "R1 ready after error", readyAfter, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    testProgram('h4_1234, 'h3C, 5);
    testProgram('h0_00FF, 'hC3, 0);
    testSector();
    testChipToggle(5);
    testChipToggle(0);
    testTimeout();
    testInvalid();
    testProgram('h7_FFFF, 'h80, 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule